// File: doc/BRIEF.md
# Dual-Speed CPU Bus Synchronizer

This block couples a CPU clocked at four times the base bus rate to a slow legacy system bus. Every CPU access is classified by address. Local RAM accesses finish in the fast cycle they are issued, with no wait. I/O register, ROM and expansion-device accesses are held with a wait signal until the fast-cycle phase counter reaches phase 0. They then occupy one full slow cycle of four fast cycles on the slow bus.

The slow bus can be taken by video DMA or memory refresh. The halt input is sampled only in a phase-0 cycle. A pending slow access that meets a halted phase 0 is deferred to the next free slow cycle. Once a slow cycle has started, halt is ignored until it ends. Depending on where in the phase an access arrives, and whether a slow cycle is stolen, a slow access costs 4 to 11 fast cycles.

The controller has three states. `ST_IDLE` (no slow access in flight) moves directly to `ST_XFER` (slow-cycle phases 1 to 3 in progress) when a slow request meets a free phase 0. In that case the phase-0 cycle itself is the first bus cycle. Otherwise it moves to `ST_ALIGN` (waiting for a free phase 0). `ST_ALIGN` moves to `ST_XFER` on a free phase 0, or back to `ST_IDLE` if the request is withdrawn. `ST_XFER` returns to `ST_IDLE` on phase 3.

Top module: `cpu_bus_sync`

## Requirements
- R1: A 2-bit phase counter resets to 0 and advances by one every fast cycle, wrapping 3 to 0. `slow_clk` is high in phases 0 and 1 and low in phases 2 and 3.
- R2: The address decode gives `sb_space` as follows. 0xD100–0xD1FF is expansion (code 3). The rest of 0xD000–0xD7FF is I/O (code 1). 0xC000–0xCFFF and 0xD800–0xFFFF are ROM (code 2). Every other address is RAM (code 0).
- R3: A RAM access never raises `cpu_wait`. It asserts `ram_sel`, asserts `ram_we` for writes, and returns `ram_rdata` on `cpu_rdata` in the same cycle. It leaves `sb_cyc` low.
- R4: A slow-region access issued in a cycle of phase p (no halt) first drives the slow bus at the next phase 0. It completes after (4 − p) mod 4 + 4 fast cycles, counting the issue cycle.
- R5: `cpu_wait` is high in every cycle of a slow access except the last. The last cycle is phase 3 of the slow cycle.
- R6: `sb_cyc` is high for exactly four consecutive cycles per slow access, phases 0 to 3. During those cycles `sb_addr`, `sb_we` and `sb_wdata` carry the CPU access.
- R7: If `sb_halt` is high in a phase-0 cycle, a pending slow access does not start and is deferred by four fast cycles. `sb_halt` during phases 1 to 3 of a running slow cycle has no effect.
- R8: On the last cycle of a slow read, `cpu_rdata` equals `sb_rdata`. A slow write presents `sb_we` high with the CPU write data on `sb_wdata`.
- R9: In and right after reset, `cpu_wait` and `sb_cyc` are low and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access valid, held while `cpu_wait` is high |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU write enable |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data to the CPU |
| cpu_wait | output | 1 | Stall the CPU this cycle |
| ram_sel | output | 1 | Local fast RAM selected |
| ram_we | output | 1 | Local fast RAM write |
| ram_rdata | input | 8 | Local fast RAM read data |
| sb_cyc | output | 1 | CPU owns the slow bus this fast cycle |
| sb_addr | output | 16 | Slow-bus address |
| sb_we | output | 1 | Slow-bus write |
| sb_wdata | output | 8 | Slow-bus write data |
| sb_rdata | input | 8 | Slow-bus read data |
| sb_halt | input | 1 | Slow bus taken by DMA or refresh (sampled at phase 0) |
| sb_space | output | 2 | Decoded region of `cpu_addr` |
| slow_clk | output | 1 | Slow clock derived from the phase counter |

## Verification
The assertions check on every cycle that:
- the phase counter steps by one;
- a slow cycle only begins at phase 0 and never in a halted phase 0;
- an open slow cycle runs to phase 3;
- the wait drops only on a slow cycle's final phase;
- RAM accesses never wait.

Only the bench scenarios can show the end-to-end cycle costs. These are the alignment penalty for each of the four start phases, the extra four cycles from a stolen slow cycle, and the indifference to halt during a running transfer. The bench also checks the address-window boundaries and the data actually returned or written.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    typedef enum logic [1:0] {
        SP_RAM = 2'd0,
        SP_IO  = 2'd1,
        SP_ROM = 2'd2,
        SP_EXP = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_XFER  = 2'd2
    } sync_st_e;
endpackage

// File: rtl/cbs_phase.sv
module cbs_phase #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase_o,
    output logic          at_zero_o,
    output logic          at_last_o,
    output logic          slow_clk_o
);
    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + PW'(1);
    end

    assign phase_o    = phase_q;
    assign at_zero_o  = (phase_q == '0);
    assign at_last_o  = (phase_q == '1);
    assign slow_clk_o = ~phase_q[PW-1];

    // R1: counter steps by one every fast cycle
    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_q == $past(phase_q) + PW'(1)));
endmodule

// File: rtl/cbs_decode.sv
module cbs_decode
    import cbs_pkg::*;
#(
    parameter int             AW      = 16,
    parameter logic [AW-1:0]  IO_LO   = 16'hD000,
    parameter logic [AW-1:0]  IO_HI   = 16'hD7FF,
    parameter logic [AW-1:0]  EXP_LO  = 16'hD100,
    parameter logic [AW-1:0]  EXP_HI  = 16'hD1FF,
    parameter logic [AW-1:0]  ROMA_LO = 16'hC000,
    parameter logic [AW-1:0]  ROMA_HI = 16'hCFFF,
    parameter logic [AW-1:0]  ROMB_LO = 16'hD800
) (
    input  logic [AW-1:0] addr_i,
    output space_e        space_o,
    output logic          slow_o
);
    always_comb begin
        if (addr_i >= EXP_LO && addr_i <= EXP_HI)
            space_o = SP_EXP;
        else if (addr_i >= IO_LO && addr_i <= IO_HI)
            space_o = SP_IO;
        else if ((addr_i >= ROMA_LO && addr_i <= ROMA_HI) || addr_i >= ROMB_LO)
            space_o = SP_ROM;
        else
            space_o = SP_RAM;
    end

    assign slow_o = (space_o != SP_RAM);
endmodule

// File: rtl/cbs_fsm.sv
module cbs_fsm
    import cbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slow_req_i,
    input  logic at_zero_i,
    input  logic at_last_i,
    input  logic halt_i,
    output logic bus_act_o,
    output logic wait_o
);
    sync_st_e state_q, state_d;
    logic     free_slot;
    logic     done;

    assign free_slot = at_zero_i && !halt_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        bus_act_o = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (slow_req_i) begin
                    if (free_slot) begin
                        state_d   = ST_XFER;
                        bus_act_o = 1'b1;
                    end else begin
                        state_d = ST_ALIGN;
                    end
                end
            end
            ST_ALIGN: begin
                if (!slow_req_i) begin
                    state_d = ST_IDLE;
                end else if (free_slot) begin
                    state_d   = ST_XFER;
                    bus_act_o = 1'b1;
                end
            end
            ST_XFER: begin
                bus_act_o = 1'b1;
                if (at_last_i) begin
                    state_d = ST_IDLE;
                    done    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        wait_o = slow_req_i && !done;
    end

    // R4: a slow cycle opens only at phase 0
    p_start_phase0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_act_o) |-> at_zero_i);
    // R7: never start into a halted phase 0
    p_halt_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act_o && at_zero_i) |-> !halt_i);
    // R6: an open slow cycle runs through phase 3
    p_xfer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act_o && !at_last_i) |=> bus_act_o);
    // R5: wait released only on the final slow phase
    p_wait_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_req_i && !wait_o) |-> (bus_act_o && at_last_i));
endmodule

// File: rtl/cpu_bus_sync.sv
module cpu_bus_sync
    import cbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_wait,
    output logic          ram_sel,
    output logic          ram_we,
    input  logic [DW-1:0] ram_rdata,
    output logic          sb_cyc,
    output logic [AW-1:0] sb_addr,
    output logic          sb_we,
    output logic [DW-1:0] sb_wdata,
    input  logic [DW-1:0] sb_rdata,
    input  logic          sb_halt,
    output logic [1:0]    sb_space,
    output logic          slow_clk
);
    logic [PW-1:0] phase;
    logic          at_zero, at_last;
    space_e        space;
    logic          is_slow, slow_req, bus_act;

    cbs_phase #(.PW(PW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase),
        .at_zero_o  (at_zero),
        .at_last_o  (at_last),
        .slow_clk_o (slow_clk)
    );

    cbs_decode #(.AW(AW)) u_decode (
        .addr_i  (cpu_addr),
        .space_o (space),
        .slow_o  (is_slow)
    );

    assign slow_req = cpu_req && is_slow;

    cbs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_req_i (slow_req),
        .at_zero_i  (at_zero),
        .at_last_i  (at_last),
        .halt_i     (sb_halt),
        .bus_act_o  (bus_act),
        .wait_o     (cpu_wait)
    );

    always_comb begin
        ram_sel   = cpu_req && !is_slow;
        ram_we    = ram_sel && cpu_we;
        sb_cyc    = bus_act;
        sb_addr   = bus_act ? cpu_addr  : '0;
        sb_we     = bus_act && cpu_we;
        sb_wdata  = bus_act ? cpu_wdata : '0;
        sb_space  = space;
        cpu_rdata = is_slow ? sb_rdata : ram_rdata;
    end

    // R3: RAM accesses never stall
    p_ram_nowait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (!cpu_wait && !sb_cyc));
    // R1: slow clock rises with phase 0
    p_slowclk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_clk) |-> (phase == '0));
endmodule

// File: tb/cpu_bus_sync_bench.sv
module cpu_bus_sync_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         cycles;
        logic       slow;
        logic       we;
        logic [7:0] data;
        logic [1:0] space;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_wait;
    logic        ram_sel, ram_we;
    logic [7:0]  ram_rdata;
    logic        sb_cyc;
    logic [15:0] sb_addr;
    logic        sb_we;
    logic [7:0]  sb_wdata;
    logic [7:0]  sb_rdata;
    logic        sb_halt = 1'b0;
    logic [1:0]  sb_space;
    logic        slow_clk;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t exp_q[$];
    logic [1:0] tb_ph;
    int   mon_cnt = 0;
    int   mon_bus = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ram_rdata = cpu_addr[7:0] ^ 8'hC3;
    assign sb_rdata  = sb_cyc ? (sb_addr[7:0] ^ 8'h5A) : 8'hEE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_ph <= 2'd0;
        else        tb_ph <= tb_ph + 2'd1;
    end

    cpu_bus_sync u_cpu_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
        .ram_sel(ram_sel), .ram_we(ram_we), .ram_rdata(ram_rdata),
        .sb_cyc(sb_cyc), .sb_addr(sb_addr), .sb_we(sb_we),
        .sb_wdata(sb_wdata), .sb_rdata(sb_rdata), .sb_halt(sb_halt),
        .sb_space(sb_space), .slow_clk(slow_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: counts the cycles of each access and scores it on completion
    always @(negedge clk) begin
        if (rst_n && cpu_req) begin
            mon_cnt = mon_cnt + 1;
            if (sb_cyc) begin
                mon_bus = mon_bus + 1;
                check(sb_addr == cpu_addr, "R6 sb_addr", sb_addr, cpu_addr);
            end
            if (!cpu_wait) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected completion", 0, 1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mon_cnt == e.cycles, {e.tag, " cycles"}, mon_cnt, e.cycles);
                    check(sb_space == e.space, "R2 region", sb_space, e.space);
                    if (e.slow) begin
                        check(mon_bus == 4, "R6 bus cycles", mon_bus, 4);
                        check(sb_cyc && slow_clk == 1'b0, "R5 final phase", sb_cyc, 1);
                        if (e.we) begin
                            check(sb_we == 1'b1, "R8 sb_we", sb_we, 1);
                            check(sb_wdata == e.data, "R8 wdata", sb_wdata, e.data);
                        end else begin
                            check(cpu_rdata == e.data, "R8 rdata", cpu_rdata, e.data);
                        end
                    end else begin
                        check(mon_bus == 0 && ram_sel, "R3 ram only", mon_bus, 0);
                        check(ram_we == e.we, "R3 ram_we", ram_we, e.we);
                        if (!e.we)
                            check(cpu_rdata == e.data, "R3 rdata", cpu_rdata, e.data);
                    end
                end
                mon_cnt = 0;
                mon_bus = 0;
            end
        end
    end

    function automatic logic [1:0] region(input logic [15:0] a);
        if (a >= 16'hD100 && a <= 16'hD1FF) return 2'd3;
        if (a >= 16'hD000 && a <= 16'hD7FF) return 2'd1;
        if ((a >= 16'hC000 && a <= 16'hCFFF) || a >= 16'hD800) return 2'd2;
        return 2'd0;
    endfunction

    // mode 0: no halt; 1: halt one phase 0; 2: halt during transfer phases 1..3
    task automatic access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                          input int p, input int mode);
        exp_t e;
        logic sl;
        sl = (region(a) != 2'd0);
        do begin
            @(posedge clk); #1;
        end while (tb_ph != 2'(p));
        e.slow  = sl;
        e.we    = we;
        e.space = region(a);
        e.data  = we ? wd : (a[7:0] ^ (sl ? 8'h5A : 8'hC3));
        e.cycles = sl ? (((4 - p) % 4) + 4 + (mode == 1 ? 4 : 0)) : 1;
        e.tag   = !sl ? "R3" : (mode != 0 ? "R7" : "R4");
        exp_q.push_back(e);
        cpu_req = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
        if (mode == 1) sb_halt = 1'b1;
        forever begin
            @(negedge clk);
            if (!cpu_wait) break;
            @(posedge clk); #1;
            if (mode == 1 && tb_ph == 2'd1) sb_halt = 1'b0;
            if (mode == 2 && tb_ph == 2'd1) sb_halt = 1'b1;
        end
        @(posedge clk); #1;
        cpu_req = 1'b0; sb_halt = 1'b0; cpu_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!cpu_wait && !sb_cyc, "R9 in reset", cpu_wait, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!cpu_wait && !sb_cyc, "R9 idle", sb_cyc, 0);
            check(slow_clk == (tb_ph < 2'd2), "R1 slow_clk", slow_clk, tb_ph < 2'd2);
        end
        for (int p = 0; p < 4; p++) begin
            access(16'hD40A, 1'b0, 8'h00, p, 0);
            access(16'hE123, 1'b0, 8'h00, p, 0);
            access(16'hD1F0, 1'b0, 8'h00, p, 0);
            access(16'h0600, 1'b0, 8'h00, p, 0);
            access(16'hD000, 1'b1, 8'(8'h30 + p), p, 0);
            access(16'h4321, 1'b1, 8'h77, p, 0);
            access(16'hD01A, 1'b1, 8'(8'h90 + p), p, 1);
            access(16'hF800, 1'b0, 8'h00, p, 1);
        end
        access(16'hD40A, 1'b1, 8'hA5, 0, 2);
        access(16'hD018, 1'b0, 8'h00, 0, 2);
        access(16'hBFFF, 1'b0, 8'h00, 1, 0);
        access(16'hC000, 1'b0, 8'h00, 2, 0);
        access(16'hCFFF, 1'b0, 8'h00, 3, 0);
        access(16'hD7FF, 1'b0, 8'h00, 0, 0);
        access(16'hD800, 1'b0, 8'h00, 1, 0);
        access(16'hD0FF, 1'b0, 8'h00, 2, 0);
        access(16'hD200, 1'b0, 8'h00, 3, 0);
        access(16'hFFFF, 1'b0, 8'h00, 0, 0);
        // back-to-back aligned slow accesses each take four cycles
        access(16'hD300, 1'b0, 8'h00, 0, 0);
        access(16'hD301, 1'b0, 8'h00, 0, 0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 all completed", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule